// File: doc/BRIEF.md
# Transmit DMA Request Generator

This block produces the active-low DMA request lines for the transmit side of a serial controller. A request means one thing: the single transmit holding register can take another character. The DMA controller answers each request with one write. The block watches four things: the holding register's empty flag, the CPU write strobe together with its address-match qualifier, and the framing mode. The fourth is a pulse that marks the moment the closing flag or sync character enters the shift register after the CRC.

There are two request pins. The first is a dedicated request pin. It has a mode-select bit and an enable bit. The second pin is shared with a general-purpose DTR output. When its request mode is off, that pin drives the inverse of a DTR control bit. In synchronous or SDLC framing, the end-of-CRC pulse raises the request for one clock cycle. The DMA then sees a fresh falling edge and can load the first character of the next frame. A qualified write to the holding register withdraws the request at once. The request is not raised again until the register has been seen full and has then emptied. This gives exactly one falling edge per character.

Top module: `txdma_req_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both `req_n` and `dtr_req_n` are 1 after that edge.
- R2: If `req_sel` or `req_en` is 0 at a clock edge, `req_n` is 1 after that edge.
- R3: With the dedicated pin selected and enabled and no write pending, `req_n` becomes the inverse of `thr_empty` one cycle after the flag changes. A value of 1 on `thr_empty` means the register is empty. `req_n` stays low for as long as the register stays empty.
- R4: A falling edge of `wr_n` with `wr_sel`=1 sets both request pins (in request mode) high after the edge on which `wr_n` is first seen low. They stay high while `thr_empty` stays 1. The block resumes normal tracking once `thr_empty` has been seen at 0.
- R5: A falling edge of `wr_n` with `wr_sel`=0 has no effect on either pin.
- R6: With `sync_mode`=1, a cycle with `eoc_load`=1 drives both request pins high for exactly the following cycle. This happens even though the holding register is empty.
- R7: With `sync_mode`=0 (asynchronous framing), `eoc_load` has no effect.
- R8: If `eoc_load` and a qualified write falling edge occur in the same cycle, the write wins. The request stays high after the pulse cycle, until the register has been filled and has emptied again.
- R9: With `dtr_req_mode`=0, `dtr_req_n` equals the inverse of `dtr_bit`, one cycle later.
- R10: With `dtr_req_mode`=1, `dtr_req_n` carries the same request as the dedicated pin, whatever the values of `req_sel` and `req_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (hardware or channel reset) |
| sync_mode | input | 1 | 1 = synchronous/SDLC framing, 0 = asynchronous |
| req_sel | input | 1 | Dedicated pin set to request function |
| req_en | input | 1 | Enable bit for the dedicated request |
| dtr_req_mode | input | 1 | Shared pin set to request function (0 = DTR output) |
| dtr_bit | input | 1 | DTR control bit, driven inverted in DTR mode |
| thr_empty | input | 1 | Transmit holding register empty flag |
| wr_n | input | 1 | CPU write strobe, active low |
| wr_sel | input | 1 | Write addresses this channel's holding register |
| eoc_load | input | 1 | Closing flag or sync loaded into shift register after CRC |
| req_n | output | 1 | Dedicated DMA request, active low |
| dtr_req_n | output | 1 | Shared DTR / DMA request pin, active low |

## Verification
Two functions can fall in the same cycle: the end-of-CRC pulse and a qualified write edge. Both want the pin high, but they differ in what follows. The pulse releases the request after one cycle, while the write holds it off until the register has refilled and emptied. The bench drives both together in one vector and then keeps the register empty for a further cycle. The request must still be high in that cycle, which shows the write took priority. A later full-then-empty sequence must then bring the request low again.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam logic PIN_IDLE = 1'b1;

  typedef enum logic {
    FRAME_ASYNC = 1'b0,
    FRAME_SYNC  = 1'b1
  } frame_e;
endpackage

// File: rtl/txdma_wr_edge.sv
module txdma_wr_edge (
  input  logic clk,
  input  logic rst,
  input  logic wr_n,
  input  logic wr_sel,
  output logic wr_hit
);
  logic wr_n_q;

  always_ff @(posedge clk) begin
    if (rst) wr_n_q <= 1'b1;
    else     wr_n_q <= wr_n;
  end

  assign wr_hit = wr_n_q & ~wr_n & wr_sel;
endmodule

// File: rtl/txdma_req_core.sv
module txdma_req_core
  import txdma_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  frame_e frame,
  input  logic   thr_empty,
  input  logic   wr_hit,
  input  logic   eoc_load,
  output logic   pend
);
  logic held_q, held_d, eoc_gap;

  always_comb begin
    held_d = held_q;
    if (wr_hit)          held_d = 1'b1;
    else if (!thr_empty) held_d = 1'b0;
  end

  assign eoc_gap = (frame == FRAME_SYNC) & eoc_load;
  assign pend    = thr_empty & ~held_d & ~eoc_gap;

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= held_d;
  end
endmodule

// File: rtl/txdma_pin_out.sv
module txdma_pin_out
  import txdma_pkg::*;
#(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_d,
  output logic [NPIN-1:0] pin_q
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pin_q[i] <= PIN_IDLE;
      else     pin_q[i] <= pin_d[i];
    end
  end
endmodule

// File: rtl/txdma_req_gen.sv
module txdma_req_gen
  import txdma_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sync_mode,
  input  logic req_sel,
  input  logic req_en,
  input  logic dtr_req_mode,
  input  logic dtr_bit,
  input  logic thr_empty,
  input  logic wr_n,
  input  logic wr_sel,
  input  logic eoc_load,
  output logic req_n,
  output logic dtr_req_n
);
  localparam int NPIN = 2;

  logic            wr_hit, pend;
  logic [NPIN-1:0] pin_d, pin_q;
  frame_e          frame;

  assign frame = sync_mode ? FRAME_SYNC : FRAME_ASYNC;

  txdma_wr_edge u_edge (
    .clk(clk), .rst(rst), .wr_n(wr_n), .wr_sel(wr_sel), .wr_hit(wr_hit)
  );

  txdma_req_core u_core (
    .clk(clk), .rst(rst), .frame(frame), .thr_empty(thr_empty),
    .wr_hit(wr_hit), .eoc_load(eoc_load), .pend(pend)
  );

  assign pin_d[0] = ~(req_sel & req_en & pend);
  assign pin_d[1] = dtr_req_mode ? ~pend : ~dtr_bit;

  txdma_pin_out #(.NPIN(NPIN)) u_pins (
    .clk(clk), .rst(rst), .pin_d(pin_d), .pin_q(pin_q)
  );

  assign req_n     = pin_q[0];
  assign dtr_req_n = pin_q[1];
endmodule

// File: rtl/txdma_req_chk.sv
module txdma_req_chk (
  input logic clk,
  input logic rst,
  input logic sync_mode,
  input logic req_sel,
  input logic req_en,
  input logic dtr_req_mode,
  input logic dtr_bit,
  input logic thr_empty,
  input logic wr_n,
  input logic wr_sel,
  input logic eoc_load,
  input logic req_n,
  input logic dtr_req_n
);
  logic rst_seen = 1'b0;

  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen) begin
      AST_RESET_IDLE: assert (req_n && dtr_req_n); // R1
    end
  end

  AST_OFF_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!req_sel || !req_en) |=> req_n); // R2

  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
    !thr_empty |=> (req_n && (dtr_req_n || !$past(dtr_req_mode)))); // R3

  AST_WRITE_DROP: assert property (@(posedge clk) disable iff (rst)
    ($fell(wr_n) && wr_sel) |=> req_n); // R4

  AST_EOC_GAP: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && eoc_load) |=> req_n); // R6

  AST_DTR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !dtr_req_mode |=> (dtr_req_n == !$past(dtr_bit))); // R9
endmodule

bind txdma_req_gen txdma_req_chk u_chk (.*);

// File: tb/sim_txdma_req_gen.sv
module sim_txdma_req_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_mode = 0, req_sel = 0, req_en = 0, dtr_req_mode = 0, dtr_bit = 0;
  logic thr_empty = 0, wr_n = 1, wr_sel = 0, eoc_load = 0;
  logic req_n, dtr_req_n;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  txdma_req_gen u0 (.*);

  // fields: sync sel en dtrmode dtr empty wr_n wr_sel eoc | exp_req exp_dtr
  localparam int NV = 18;
  localparam logic [10:0] VEC [NV] = '{
    11'b0_1_0_0_1_1_1_0_0_1_0,  // R2 disabled, R9 dtr=1
    11'b0_1_1_0_1_1_1_0_0_0_0,  // R3 enabled empty
    11'b0_1_1_1_0_1_1_0_0_0_0,  // R10 shared request
    11'b0_1_1_1_0_1_0_1_0_1_1,  // R4 qualified write
    11'b0_1_1_1_0_0_1_0_0_1_1,  // R4 register full
    11'b0_1_1_1_0_1_1_0_0_0_0,  // R3 empty again
    11'b0_1_1_1_0_1_1_0_1_0_0,  // R7 async eoc ignored
    11'b1_1_1_1_0_1_1_0_1_1_1,  // R6 sync eoc gap
    11'b1_1_1_1_0_1_1_0_0_0_0,  // R6 gap over
    11'b1_1_1_1_0_1_0_0_0_0_0,  // R5 unqualified write
    11'b1_1_1_1_0_1_1_0_0_0_0,  // R5 strobe release
    11'b1_1_1_1_0_1_0_1_1_1_1,  // R8 write + eoc
    11'b1_1_1_1_0_1_1_0_0_1_1,  // R8 still held
    11'b1_1_1_1_0_0_1_0_0_1_1,  // R8 filled
    11'b1_1_1_1_0_1_1_0_0_0_0,  // R8 emptied -> request
    11'b1_1_0_1_0_1_1_0_0_1_0,  // R2 en off, R10 shared stays
    11'b1_1_0_0_1_1_1_0_0_1_0,  // R9 dtr=1
    11'b1_1_0_0_0_1_1_0_0_1_1   // R9 dtr=0
  };

  task automatic check(input string tag, input logic a_req, input logic a_dtr,
                       input logic e_req, input logic e_dtr);
    total++;
    if (a_req !== e_req || a_dtr !== e_dtr) begin
      bad++;
      $display("FAIL %s: req_n/dtr_req_n = %b%b expected %b%b", tag, a_req, a_dtr, e_req, e_dtr);
    end
  endtask

  task automatic drive(input logic [10:0] v);
    {sync_mode, req_sel, req_en, dtr_req_mode, dtr_bit, thr_empty, wr_n, wr_sel, eoc_load} = v[10:2];
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset", req_n, dtr_req_n, 1'b1, 1'b1);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("vector %0d", i), req_n, dtr_req_n, VEC[i][1], VEC[i][0]);
    end
    // R1: reset in the middle of an active request
    drive(11'b0_1_1_1_0_1_1_0_0_0_0);
    @(negedge clk);
    check("R3 active before reset", req_n, dtr_req_n, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", req_n, dtr_req_n, 1'b1, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check("R3 resume after reset", req_n, dtr_req_n, 1'b0, 1'b0);
    // R2: select clear alone forces dedicated pin high
    req_sel = 1'b0;
    @(negedge clk);
    check("R2 select clear", req_n, dtr_req_n, 1'b1, 1'b0);
    // R5: held-low strobe is not a new edge
    req_sel = 1'b1; wr_n = 1'b0; wr_sel = 1'b0;
    @(negedge clk);
    wr_sel = 1'b1;
    @(negedge clk);
    check("R5 no edge while held low", req_n, dtr_req_n, 1'b0, 1'b0);
    wr_n = 1'b1; wr_sel = 1'b0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule